// File: doc/BRIEF.md
# Triggered Channel-Pattern Event Recorder

This block sits behind the discriminators of a multi-channel front-end and keeps a record of every cycle in which at least one discriminator bit is high. Each accepted trigger writes one record into the next free memory slot. A record holds the complete discriminator pattern of every channel, not just the channels that fired. It also holds the bunch-crossing stamp for that cycle in Gray code and a header carrying the slot number. A bunch-crossing counter runs on every clock from the start of each acquisition.

An acquisition begins with a one-cycle `acq_start` pulse. This pulse clears the slot count, the full flag, the read position and the bunch-crossing counter. Recording then continues until every slot is used. At that point `ram_full` rises and the memory freezes until the next `acq_start`. The readout node sees `event_count` and pulls records out in write order through a request/valid read port.

Top module: `hit_event_recorder`

## Requirements
- R1: After synchronous reset, `ram_full` is 0, `event_count` is 0 and `rd_valid` is 0.
- R2: A record is captured when any single bit of `disc` is high. The stored `rd_hits` field equals the whole `disc` vector from the trigger cycle, with channel c on bits [2c+1:2c].
- R3: A cycle with `disc` all zero stores nothing, and `event_count` is unchanged.
- R4: The bunch-crossing count is cleared by `acq_start` and rises by one on every clock edge afterwards, wrapping at 4096. The stored `rd_bcid` is the Gray code (b ^ b>>1) of the count value present in the trigger cycle.
- R5: The stored `rd_header` is the slot index of the record, counted from 0 at the start of the acquisition.
- R6: Triggers on consecutive cycles each take their own slot. `event_count` rises by exactly one per triggering cycle.
- R7: When the number of stored events reaches the depth (128), `ram_full` is 1. While it is set, triggers are ignored and `event_count` stays at 128.
- R8: An `acq_start` pulse clears `event_count`, `ram_full` and the read position. A trigger in the same cycle as `acq_start` is not stored.
- R9: Records come out in write order. Each `rd_req` with an unread record yields `rd_valid` = 1 and that record on the next cycle. A `rd_req` with nothing left to read yields `rd_valid` = 0.
- R10: Between reset and the first `acq_start`, triggers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_start | input | 1 | One-cycle pulse that opens a new acquisition |
| disc | input | 128 | Discriminator bits, 2 per channel for 64 channels |
| rd_req | input | 1 | Request for the next stored record |
| ram_full | output | 1 | All slots used; recording frozen |
| event_count | output | 8 | Records stored in this acquisition |
| rd_valid | output | 1 | Read fields hold a record this cycle |
| rd_header | output | 8 | Slot index of the record read |
| rd_bcid | output | 12 | Gray-coded bunch-crossing stamp of the record read |
| rd_hits | output | 128 | Channel pattern of the record read |

## Verification
The recorder is driven with a table of patterns applied on back-to-back cycles:
- A single low bit, a single top bit and a mid-vector bit show that one hit anywhere triggers and lands in the right position.
- An all-ones vector and two alternating patterns show that the whole pattern is stored rather than only the firing channel.
- Zero vectors placed between hits show that idle cycles consume neither a slot nor a header number.
- Read-back of these records checks their order and the Gray stamp of each trigger cycle.

Further stimulus covers a trigger before the first acquisition and a trigger coinciding with `acq_start`. A stream longer than the depth shows the memory freezing at exactly 128 records. A restart then shows the counters and the stamp cleared.

// File: rtl/hrec_pkg.sv
package hrec_pkg;

    localparam int DEF_NUM_CH = 64;
    localparam int DEF_HIT_W  = 2;
    localparam int DEF_DEPTH  = 128;
    localparam int DEF_BCID_W = 12;
    localparam int DEF_HDR_W  = 8;

    typedef enum logic [1:0] {
        ACQ_IDLE   = 2'd0,
        ACQ_RUN    = 2'd1,
        ACQ_FROZEN = 2'd2
    } acq_state_e;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/hrec_trigger_or.sv
module hrec_trigger_or #(
    parameter int NUM_CH = hrec_pkg::DEF_NUM_CH,
    parameter int HIT_W  = hrec_pkg::DEF_HIT_W,
    localparam int DW    = NUM_CH * HIT_W
) (
    input  logic [DW-1:0] disc,
    output logic          trig
);

    logic [NUM_CH-1:0] chan_hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign chan_hit[c] = |disc[c*HIT_W +: HIT_W];
    end

    assign trig = |chan_hit;

endmodule

// File: rtl/hrec_bx_counter.sv
module hrec_bx_counter #(
    parameter int BCID_W = hrec_pkg::DEF_BCID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    output logic [BCID_W-1:0] bcid_gray
);
    import hrec_pkg::*;

    logic [BCID_W-1:0] bin_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bin_q <= '0;
        end else begin
            bin_q <= bin_q + 1'b1;
        end
    end

    assign bcid_gray = BCID_W'(bin_to_gray(32'(bin_q)));

    // R4: successive stamps differ in exactly one bit while counting
    assert_gray_step_R4: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ($countones(bcid_gray ^ $past(bcid_gray)) == 1));

    // R8: a start pulse returns the stamp to zero
    assert_bx_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bcid_gray == '0));

endmodule

// File: rtl/hrec_event_store.sv
module hrec_event_store #(
    parameter int DEPTH  = hrec_pkg::DEF_DEPTH,
    parameter int DW     = hrec_pkg::DEF_NUM_CH * hrec_pkg::DEF_HIT_W,
    parameter int BCID_W = hrec_pkg::DEF_BCID_W,
    parameter int HDR_W  = hrec_pkg::DEF_HDR_W,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int REC_W = HDR_W + BCID_W + DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_hits,
    input  logic [BCID_W-1:0] wr_bcid,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [HDR_W-1:0]  rd_header,
    output logic [BCID_W-1:0] rd_bcid,
    output logic [DW-1:0]     rd_hits,
    output logic [CNT_W-1:0]  count,
    output logic              full
);

    logic [REC_W-1:0] mem [DEPTH];
    logic [REC_W-1:0] rd_q;
    logic [CNT_W-1:0] rd_ptr;
    logic [REC_W-1:0] wr_rec;
    logic             rd_hit;

    assign wr_rec = {HDR_W'(count), wr_bcid, wr_hits};
    assign rd_hit = rd_req && (rd_ptr < count);

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            mem[count[AW-1:0]] <= wr_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            full  <= 1'b0;
        end else if (wr_en && !full) begin
            count <= count + 1'b1;
            full  <= (count == CNT_W'(DEPTH - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_ptr   <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_hit;
            if (rd_hit) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rd_hit && !clr) begin
            rd_q <= mem[rd_ptr[AW-1:0]];
        end
    end

    assign rd_header = rd_q[REC_W-1 -: HDR_W];
    assign rd_bcid   = rd_q[DW +: BCID_W];
    assign rd_hits   = rd_q[DW-1:0];

    // R7: the front gate never offers a write into a full memory
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    // R7: a full memory keeps its count until restarted
    assert_full_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> $stable(count));

    // R6: at most one capture per clock
    assert_one_per_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));

    // R8: restart clears count, flag and read side
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((count == '0) && !full && !rd_valid));

    // R9: reading past the last record gives no data
    assert_rd_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !clr && (rd_ptr == count)) |=> !rd_valid);

endmodule

// File: rtl/hit_event_recorder.sv
module hit_event_recorder #(
    parameter int NUM_CH = hrec_pkg::DEF_NUM_CH,
    parameter int HIT_W  = hrec_pkg::DEF_HIT_W,
    parameter int DEPTH  = hrec_pkg::DEF_DEPTH,
    parameter int BCID_W = hrec_pkg::DEF_BCID_W,
    parameter int HDR_W  = hrec_pkg::DEF_HDR_W,
    localparam int DW    = NUM_CH * HIT_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acq_start,
    input  logic [DW-1:0]     disc,
    input  logic              rd_req,
    output logic              ram_full,
    output logic [CNT_W-1:0]  event_count,
    output logic              rd_valid,
    output logic [HDR_W-1:0]  rd_header,
    output logic [BCID_W-1:0] rd_bcid,
    output logic [DW-1:0]     rd_hits
);
    import hrec_pkg::*;

    acq_state_e        st_q;
    logic              trig;
    logic              wr_en;
    logic [BCID_W-1:0] bcid_now;

    hrec_trigger_or #(.NUM_CH(NUM_CH), .HIT_W(HIT_W)) u_trig (
        .disc (disc),
        .trig (trig)
    );

    hrec_bx_counter #(.BCID_W(BCID_W)) u_bx (
        .clk       (clk),
        .rst       (rst),
        .clr       (acq_start),
        .bcid_gray (bcid_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ACQ_IDLE;
        end else if (acq_start) begin
            st_q <= ACQ_RUN;
        end else if ((st_q == ACQ_RUN) && ram_full) begin
            st_q <= ACQ_FROZEN;
        end
    end

    assign wr_en = trig && !acq_start && (st_q == ACQ_RUN) && !ram_full;

    hrec_event_store #(
        .DEPTH  (DEPTH),
        .DW     (DW),
        .BCID_W (BCID_W),
        .HDR_W  (HDR_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (acq_start),
        .wr_en     (wr_en),
        .wr_hits   (disc),
        .wr_bcid   (bcid_now),
        .rd_req    (rd_req),
        .rd_valid  (rd_valid),
        .rd_header (rd_header),
        .rd_bcid   (rd_bcid),
        .rd_hits   (rd_hits),
        .count     (event_count),
        .full      (ram_full)
    );

    // R10: nothing is recorded before the first acquisition opens
    assert_idle_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ACQ_IDLE) && !acq_start) |=> (event_count == '0));

    // R7: the frozen state is only reached with the memory full
    assert_frozen_full_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ACQ_FROZEN) |-> ram_full);

    // R3: a capture needs at least one discriminator bit
    assert_capture_needs_hit_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (disc != '0));

endmodule

// File: tb/sim_hit_event_recorder.sv
`timescale 1ns/1ps
module sim_hit_event_recorder;

    localparam int DW    = 128;
    localparam int DEPTH = 128;
    localparam int NVEC  = 8;

    localparam logic [DW-1:0] VEC [NVEC] = '{
        128'h0,
        128'h1,
        {1'b1, 127'h0},
        {128{1'b1}},
        128'h0,
        {64{2'b01}},
        {64{2'b10}},
        (128'h1 << 63)
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acq_start = 1'b0;
    logic [DW-1:0] disc = '0;
    logic          rd_req = 1'b0;
    logic          ram_full;
    logic [7:0]    event_count;
    logic          rd_valid;
    logic [7:0]    rd_header;
    logic [11:0]   rd_bcid;
    logic [DW-1:0] rd_hits;

    always #4 clk = ~clk;

    hit_event_recorder u0 (
        .clk         (clk),
        .rst         (rst),
        .acq_start   (acq_start),
        .disc        (disc),
        .rd_req      (rd_req),
        .ram_full    (ram_full),
        .event_count (event_count),
        .rd_valid    (rd_valid),
        .rd_header   (rd_header),
        .rd_bcid     (rd_bcid),
        .rd_hits     (rd_hits)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int            m_bx  = 0;
    bit            m_run = 0;
    int            m_cnt = 0;
    int            m_rd  = 0;
    logic [7:0]    e_hdr  [DEPTH];
    logic [11:0]   e_bcid [DEPTH];
    logic [DW-1:0] e_hits [DEPTH];

    function automatic logic [11:0] gray12(input int b);
        logic [11:0] v;
        v = 12'(b);
        return v ^ (v >> 1);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [159:0] act, input logic [159:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_bx = 0; m_run = 0; m_cnt = 0; m_rd = 0;
        end else if (acq_start) begin
            m_bx = 0; m_run = 1; m_cnt = 0; m_rd = 0;
        end else begin
            if (m_run && (disc != '0) && (m_cnt < DEPTH)) begin
                e_hdr[m_cnt]  = 8'(m_cnt);
                e_bcid[m_cnt] = gray12(m_bx);
                e_hits[m_cnt] = disc;
                m_cnt++;
            end
            m_bx = (m_bx + 1) % 4096;
        end
        @(negedge clk);
    endtask

    task automatic start_acq();
        acq_start = 1'b1;
        tick();
        acq_start = 1'b0;
    endtask

    task automatic read_records(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            rd_req = 1'b1;
            tick();
            check(rd_valid && rd_header == e_hdr[m_rd] && rd_bcid == e_bcid[m_rd]
                  && rd_hits == e_hits[m_rd], req,
                  {rd_valid, 7'h0, rd_header, rd_bcid, rd_hits},
                  {1'b1, 7'h0, e_hdr[m_rd], e_bcid[m_rd], e_hits[m_rd]});
            m_rd++;
        end
        rd_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        // R1: reset state
        check(!ram_full && event_count == 0 && !rd_valid, "R1",
              {ram_full, event_count, rd_valid}, 160'h0);
        rst = 1'b0;
        tick();

        // R10: triggers before the first acquisition
        disc = {128{1'b1}};
        repeat (3) tick();
        disc = '0;
        tick();
        check(event_count == 0, "R10", event_count, 0);

        // R8: trigger coinciding with the start pulse is dropped
        disc = 128'h3;
        start_acq();
        disc = '0;
        check(event_count == 0 && !ram_full, "R8 start with hit", event_count, 0);
        repeat (2) tick();

        // R2 R3 R6: table of patterns on consecutive cycles
        for (int v = 0; v < NVEC; v++) begin
            disc = VEC[v];
            tick();
        end
        disc = '0;
        tick();
        check(event_count == 6, "R6 R3 count after table", event_count, 6);

        // R9 R4 R5 R2: read back in order
        read_records(6, "R9 R4 R5 R2 readback");
        rd_req = 1'b1;
        tick();
        rd_req = 1'b0;
        check(!rd_valid, "R9 read past end", rd_valid, 0);

        // R7: overfill the memory
        start_acq();
        disc = {64{2'b10}};
        repeat (DEPTH + 5) tick();
        disc = '0;
        tick();
        check(ram_full, "R7 full flag", ram_full, 1);
        check(event_count == 8'(DEPTH), "R7 count held", event_count, DEPTH);
        disc = 128'h1;
        repeat (2) tick();
        disc = '0;
        check(event_count == 8'(DEPTH), "R7 trigger ignored when full", event_count, DEPTH);
        read_records(DEPTH, "R7 R9 R4 full readback");

        // R8: restart clears everything, stamp restarts
        start_acq();
        check(event_count == 0 && !ram_full, "R8 restart clears",
              {ram_full, event_count}, 0);
        repeat (3) tick();
        disc = 128'h4;
        tick();
        disc = '0;
        tick();
        check(event_count == 1, "R8 R6 one record after restart", event_count, 1);
        read_records(1, "R8 R4 stamp after restart");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule